// File: doc/BRIEF.md
# Selectable PRBS Pattern Generator

This block is the transmit half of a link self-test. It emits a pseudo-random bit sequence as one parallel word per enabled clock. The sequence is drawn from one of four standard polynomials, and a one-hot field picks which one. The generator runs only while the test mode is on, the pattern clock gate is open and the select field is legal. In every other case it freezes and lowers its valid flag.

A polarity control sets whether the word goes out complemented. The control is active-low: with the bit cleared, which is its reset value, the pattern is inverted. Setting the bit sends the true sequence. The shift register starts from all ones after reset, and again each time test mode is switched on. It can therefore never reach the all-zero state, and a freshly enabled link always begins from the same known point of the sequence.

Top module: `prbs_gen`

## Requirements
- R1: While rstN is low, and on the first clock after it, patValid is 0 and patWord is all zeros.
- R2: polySel is one-hot. Bit 0 selects PRBS7 (x^7+x^6+1), bit 1 PRBS9 (x^9+x^5+1), bit 2 PRBS23 (x^23+x^18+1) and bit 3 PRBS31 (x^31+x^28+1). A single 31-bit register holds the state for all four. Each step computes a feedback bit, the XOR of state bits n-1 and t-1 for the polynomial x^n+x^t+1. The register then shifts left by one and takes that bit in at bit 0. The bit emitted by the step is the feedback bit.
- R3: When testEn, clkEn and a one-hot polySel are all high at a rising edge, the block advances 32 steps at that edge. After the edge patValid is 1, and patWord holds the 32 emitted bits, the first in time at bit 31.
- R4: The value of passThru at the advancing edge decides the word's polarity. A 0 stores the complement of the emitted bits in patWord. A 1 stores them unchanged.
- R5: The state is set to all ones by reset. It is also set to all ones at any edge where testEn is 1 and was 0 at the previous edge. When that edge also advances, the word is generated from the all-ones state.
- R6: At an edge where clkEn is 0, patValid becomes 0, and both patWord and the state hold.
- R7: At an edge where testEn is 0, patValid becomes 0 and patWord holds.
- R8: If polySel has zero bits or more than one bit set at an edge, patValid becomes 0 and both patWord and the state hold. The sequence resumes from the held state once the select is legal again.
- R9: Changing polySel between advancing edges keeps the shared state. The next word continues from that state using the newly selected feedback taps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| testEn | input | 1 | Test mode on; a rising value reseeds |
| clkEn | input | 1 | Pattern clock gate |
| polySel | input | 4 | One-hot polynomial select |
| passThru | input | 1 | 0 inverts the word, 1 sends it true |
| patWord | output | 32 | Pattern word, earliest bit at MSB |
| patValid | output | 1 | patWord was updated at the last edge |

## Verification
On every cycle, the assertions confirm four things. A valid word follows only an edge where test mode, the clock gate and a legal single-bit select were all present. The word holds whenever valid is low. Reset clears both outputs. A valid word is never all zeros or all ones, which would point to a locked-up register. The exact bit sequence, the polarity rule, reseeding on a new enable, and resumption after a gated or illegal-select pause all depend on history. Only the bench's scoreboard, comparing against its own shift-register model across scripted scenarios, can show them.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  localparam int NUM_POLY = 4;
  localparam int STATE_W  = 31;
  localparam int IDX_W    = $clog2(NUM_POLY);

  // Degree and inner tap of each x^n + x^t + 1, ordered by select bit.
  localparam int POLY_LEN [NUM_POLY] = '{7, 9, 23, 31};
  localparam int POLY_TAP [NUM_POLY] = '{6, 5, 18, 28};

  typedef struct packed {
    logic             seed;     // load all ones before use
    logic             advance;  // run a full word this edge
    logic [IDX_W-1:0] polyIdx;  // which feedback taps
  } ctrlStrobes_t;

  function automatic logic [STATE_W-1:0] stepState(input logic [STATE_W-1:0] s,
                                                   input int n, input int t);
    logic fb;
    fb = s[n-1] ^ s[t-1];
    return {s[STATE_W-2:0], fb};
  endfunction
endpackage

// File: rtl/prbs_ctrl.sv
module prbs_ctrl
  import prbs_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                testEn,
  input  logic                clkEn,
  input  logic [NUM_POLY-1:0] polySel,
  output ctrlStrobes_t        strb
);
  logic             testEnQ;
  logic             legalSel;
  logic [IDX_W-1:0] encIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) testEnQ <= 1'b0;
    else       testEnQ <= testEn;
  end

  always_comb begin
    encIdx = '0;
    for (int i = 0; i < NUM_POLY; i++)
      if (polySel[i]) encIdx = IDX_W'(i);
  end

  assign legalSel     = ($countones(polySel) == 1);
  assign strb.seed    = testEn & ~testEnQ;
  assign strb.advance = testEn & clkEn & legalSel;
  assign strb.polyIdx = encIdx;
endmodule

// File: rtl/prbs_datapath.sv
module prbs_datapath
  import prbs_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic              passThru,
  output logic [WORD_W-1:0] patWord,
  output logic              patValid
);
  localparam logic [STATE_W-1:0] SEED = '1;

  logic [STATE_W-1:0] stateQ;
  logic [STATE_W-1:0] srcState;
  logic [WORD_W-1:0]  wordOf [NUM_POLY];
  logic [STATE_W-1:0] nextOf [NUM_POLY];

  assign srcState = strb.seed ? SEED : stateQ;

  for (genvar g = 0; g < NUM_POLY; g++) begin : gPoly
    localparam int LEN = POLY_LEN[g];
    localparam int TAP = POLY_TAP[g];
    always_comb begin
      logic [STATE_W-1:0] st;
      st = srcState;
      for (int i = 0; i < WORD_W; i++) begin
        st = stepState(st, LEN, TAP);
        wordOf[g][WORD_W-1-i] = st[0];
      end
      nextOf[g] = st;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= SEED;
      patWord  <= '0;
      patValid <= 1'b0;
    end else begin
      patValid <= strb.advance;
      if (strb.advance) begin
        stateQ  <= nextOf[strb.polyIdx];
        patWord <= passThru ? wordOf[strb.polyIdx] : ~wordOf[strb.polyIdx];
      end else begin
        stateQ  <= srcState;
      end
    end
  end
endmodule

// File: rtl/prbs_gen.sv
module prbs_gen
  import prbs_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testEn,
  input  logic              clkEn,
  input  logic [3:0]        polySel,
  input  logic              passThru,
  output logic [WORD_W-1:0] patWord,
  output logic              patValid
);
  ctrlStrobes_t strb;

  prbs_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .testEn  (testEn),
    .clkEn   (clkEn),
    .polySel (polySel),
    .strb    (strb)
  );

  prbs_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .passThru (passThru),
    .patWord  (patWord),
    .patValid (patValid)
  );
endmodule

// File: rtl/prbs_gen_checker.sv
module prbs_gen_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              testEn,
  input logic              clkEn,
  input logic [3:0]        polySel,
  input logic [WORD_W-1:0] patWord,
  input logic              patValid
);
  // R1: outputs cleared after a reset edge
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (!patValid && patWord == '0));

  // R3 R6 R7: valid only after an edge with every enable present
  assert_valid_enables_R3: assert property (@(posedge clk) disable iff (!rstN)
    patValid |-> ($past(testEn) && $past(clkEn)));

  // R8: valid only after a legal single-bit select
  assert_valid_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    patValid |-> ($countones($past(polySel)) == 1));

  // R6 R7: the word holds while not valid
  assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !patValid |-> $stable(patWord));

  // R2: a seeded register never yields a flat 32-bit word
  assert_no_lockup_R2: assert property (@(posedge clk) disable iff (!rstN)
    patValid |-> (patWord != '0 && patWord != '1));
endmodule

bind prbs_gen prbs_gen_checker #(.WORD_W(WORD_W)) u_prbs_gen_checker (
  .clk      (clk),
  .rstN     (rstN),
  .testEn   (testEn),
  .clkEn    (clkEn),
  .polySel  (polySel),
  .patWord  (patWord),
  .patValid (patValid)
);

// File: tb/prbs_gen_bench.sv
module prbs_gen_bench;
  localparam int WW = 32;
  localparam int SW = 31;

  typedef struct {
    logic          v;
    logic [WW-1:0] w;
    string         tag;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          testEn = 1'b0;
  logic          clkEn = 1'b0;
  logic [3:0]    polySel = 4'b0001;
  logic          passThru = 1'b0;
  logic [WW-1:0] patWord;
  logic          patValid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  expItem_t      q[$];
  logic [SW-1:0] mState;
  logic [WW-1:0] mWord;
  logic          mTestQ;

  always #2.5 clk = ~clk;

  prbs_gen u_prbs_gen (
    .clk(clk), .rstN(rstN), .testEn(testEn), .clkEn(clkEn),
    .polySel(polySel), .passThru(passThru),
    .patWord(patWord), .patValid(patValid)
  );

  function automatic int lenOf(input int k);
    case (k) 0: return 7; 1: return 9; 2: return 23; default: return 31; endcase
  endfunction
  function automatic int tapOf(input int k);
    case (k) 0: return 6; 1: return 5; 2: return 18; default: return 28; endcase
  endfunction

  task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic drive(input logic te, input logic ce, input logic [3:0] sel,
                       input logic pt, input string tag);
    logic [SW-1:0] src;
    logic          adv;
    int            k;
    @(negedge clk);
    testEn = te; clkEn = ce; polySel = sel; passThru = pt;
    src = (te && !mTestQ) ? '1 : mState;
    adv = te && ce && ($countones(sel) == 1);
    if (adv) begin
      logic [WW-1:0] bits;
      k = 0;
      for (int i = 0; i < 4; i++) if (sel[i]) k = i;
      for (int i = 0; i < WW; i++) begin
        logic fb;
        fb = src[lenOf(k)-1] ^ src[tapOf(k)-1];
        src = {src[SW-2:0], fb};
        bits[WW-1-i] = fb;
      end
      mWord = pt ? bits : ~bits;
    end
    mState = src;
    mTestQ = te;
    q.push_back('{v: adv, w: mWord, tag: tag});
  endtask

  // Monitor: compares each edge's outputs with the queued expectation.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        expItem_t e;
        e = q.pop_front();
        check({e.tag, " valid"}, WW'(patValid), WW'(e.v));
        check({e.tag, " word"}, patWord, e.w);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mState = '1; mWord = '0; mTestQ = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", WW'(patValid), '0);
    check("R1 reset word", patWord, '0);
    @(negedge clk);
    rstN = 1'b1;

    // R5 R2 R4: seeded PRBS7, inverted by default
    for (int i = 0; i < 6; i++) drive(1, 1, 4'b0001, 0, "R2 R4 R5 prbs7 inv");
    for (int i = 0; i < 4; i++) drive(1, 1, 4'b0001, 1, "R4 prbs7 true");
    // R6: clock gate closed, then resume
    for (int i = 0; i < 3; i++) drive(1, 0, 4'b0001, 1, "R6 gate closed");
    for (int i = 0; i < 3; i++) drive(1, 1, 4'b0001, 1, "R6 resume");
    // R8: illegal selects hold, then resume
    drive(1, 1, 4'b0000, 1, "R8 no select");
    drive(1, 1, 4'b0011, 1, "R8 two selects");
    drive(1, 1, 4'b1111, 0, "R8 all selects");
    for (int i = 0; i < 2; i++) drive(1, 1, 4'b0001, 1, "R8 resume");
    // R2: the other polynomials, R9 switching on shared state
    for (int i = 0; i < 5; i++) drive(1, 1, 4'b0010, 1, "R2 R9 prbs9");
    for (int i = 0; i < 5; i++) drive(1, 1, 4'b0100, 0, "R2 R9 prbs23");
    for (int i = 0; i < 5; i++) drive(1, 1, 4'b1000, 1, "R2 R9 prbs31");
    // R7: test mode off holds, R5: re-enable reseeds
    for (int i = 0; i < 3; i++) drive(0, 1, 4'b1000, 1, "R7 test off");
    for (int i = 0; i < 4; i++) drive(1, 1, 4'b1000, 1, "R5 reseed prbs31");
    // R5: rise with gate closed still seeds
    drive(0, 1, 4'b0100, 0, "R7 test off again");
    drive(1, 0, 4'b0100, 0, "R5 seed while gated");
    for (int i = 0; i < 3; i++) drive(1, 1, 4'b0100, 0, "R5 after gated seed");
    // long PRBS7 run across its period
    for (int i = 0; i < 140; i++) drive(1, 1, 4'b0001, 0, "R3 prbs7 long");
    drive(0, 0, 4'b0001, 0, "R7 idle");
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule